// File: doc/BRIEF.md
# Jacobi Rotation Processing Element

This block is one cell of a systolic array that diagonalises a small symmetric matrix by repeated plane rotations. Each cell holds a 2x2 tile `[a b; g d]` of fixed-point values. A parameter picks one of three roles for the cell.

- **Angle cell.** It sits on the diagonal of the array. It works out the rotation angle that clears its own off-diagonal pair, rotates its tile from both sides, and publishes the cosine and sine of that angle.
- **Cross cell.** It lies off the diagonal. It takes the cosine/sine pair of its row's angle cell and the pair of its column's angle cell, and rotates its tile from the left and from the right.
- **Vector cell.** It accumulates eigenvectors. It takes only its column's pair and rotates from the right. Its tile starts as the identity.

Every cell emits the cosine/sine pair it applied on the right. Those values are the only data that neighbours exchange.

All data are signed two's complement with 14 fraction bits in 16-bit words (1.0 is 16384). Matrix values are assumed to be normalised into (-1, 1).

The angle is theta = 0.5 * atan(2b / (a - d)), which stays within ±pi/4. The angle cell finds it with one iterative shift-and-add engine. The engine first runs in vectoring mode on the pair (a - d, 2b), and the result is halved. The engine then runs in rotation mode to produce the cosine and sine. A job is accepted with a valid/ready handshake at the input. The result is held under a valid/ready handshake at the output.

Top module: `jrot_pe`

## Requirements
- R1: During and directly after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A job is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 until the result has been taken. `out_valid` stays 1 and all outputs stay unchanged while `out_ready` is 0. The cycle after `out_valid` and `out_ready` are both 1, `out_valid` is 0 and `in_ready` is 1.
- R3: In the angle role, for a symmetric tile (g = b), `out_b` and `out_g` are within 16 LSB of zero. `out_a` and `out_d` are within 16 LSB of c²a + 2csb + s²d and s²a − 2csb + c²d.
- R4: In the angle role, `out_c` and `out_s` are within 8 LSB of cos(theta) and sin(theta), with theta = 0.5·atan(2b/(a−d)). Values use 14 fraction bits.
- R5: In the angle role, a = d with b ≠ 0 gives theta = +pi/4 when b > 0 and −pi/4 when b < 0. b = 0 gives theta = 0, so the tile leaves unchanged within 16 LSB.
- R6: In the angle role, the sum of squares of the four tile values is preserved within 0.002, and c² + s² stays within 0.004 of 1.
- R7: In the cross role, the output tile is within 4 LSB of [rc rs; −rs rc]·P·[cc −cs; cs cc]. Here (rc, rs) are `row_c`/`row_s` and (cc, cs) are `col_c`/`col_s`. `out_c`/`out_s` equal `col_c`/`col_s` exactly.
- R8: In the vector role, the output tile is within 4 LSB of P·[cc −cs; cs cc]. `row_c` and `row_s` have no effect on any output.
- R9: In the vector role, an identity tile (16384, 0, 0, 16384) gives within 3 LSB the tile [cc −cs; cs cc].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Job offered |
| in_ready | output | 1 | Cell is idle and takes a job |
| in_a | input | 16 | Tile upper-left value |
| in_b | input | 16 | Tile upper-right value |
| in_g | input | 16 | Tile lower-left value |
| in_d | input | 16 | Tile lower-right value |
| row_c | input | 16 | Cosine from the row's angle cell |
| row_s | input | 16 | Sine from the row's angle cell |
| col_c | input | 16 | Cosine from the column's angle cell |
| col_s | input | 16 | Sine from the column's angle cell |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_a | output | 16 | Rotated upper-left value |
| out_b | output | 16 | Rotated upper-right value |
| out_g | output | 16 | Rotated lower-left value |
| out_d | output | 16 | Rotated lower-right value |
| out_c | output | 16 | Cosine applied on the right |
| out_s | output | 16 | Sine applied on the right |

## Verification
The bound checker watches every cycle for the handshake rules:

- a single job in flight;
- the result held stable while `out_ready` is 0;
- release after the result is taken.

It also checks, on every result of the angle cell:

- the off-diagonal pair of a symmetric tile is cleared;
- the cosine lies in the band that a quarter-turn limit allows;
- the pair has unit norm.

In the two other roles, it checks that the column pair is forwarded unchanged. Some properties need an arithmetic reference, and only the bench scenarios show them. These are:

- the exact eigenvalue values on the diagonal;
- the signed angle in the equal-diagonal and zero-coupling cases;
- the two-sided and one-sided products;
- the vector cell's indifference to the row pair.

// File: rtl/jrot_pkg.sv
package jrot_pkg;
  localparam int DW = 16;
  localparam int FW = 14;
  localparam int GW = 4;
  localparam int IW = DW + GW;
  localparam int NIT = 14;
  localparam int AW = 2 * DW + 2;
  localparam int TOL_LSB = 16;

  typedef logic signed [DW-1:0] fx_t;
  typedef logic signed [IW-1:0] cw_t;
  typedef logic signed [AW-1:0] acc_t;

  typedef struct packed {
    fx_t a;
    fx_t b;
    fx_t g;
    fx_t d;
  } quad_t;

  typedef enum logic [1:0] {
    ROLE_DIAG = 2'd0,
    ROLE_OFF  = 2'd1,
    ROLE_EIG  = 2'd2
  } role_e;

  // pi/4 and the inverse shift-add gain, both scaled by 2^FW (FW = 14)
  localparam cw_t QUARTER_PI = cw_t'(12868);
  localparam cw_t GAIN_INV   = cw_t'(9949);
  localparam fx_t FX_ONE     = fx_t'(1 << FW);

  // arctan(2^-i) scaled by 2^FW
  function automatic cw_t atan_lut(input int i);
    case (i)
      0:  return cw_t'(12868);
      1:  return cw_t'(7596);
      2:  return cw_t'(4014);
      3:  return cw_t'(2037);
      4:  return cw_t'(1023);
      5:  return cw_t'(512);
      6:  return cw_t'(256);
      7:  return cw_t'(128);
      8:  return cw_t'(64);
      9:  return cw_t'(32);
      10: return cw_t'(16);
      11: return cw_t'(8);
      12: return cw_t'(4);
      13: return cw_t'(2);
      14: return cw_t'(1);
      default: return cw_t'(0);
    endcase
  endfunction

  function automatic fx_t fx_sat(input cw_t v);
    cw_t hi;
    cw_t lo;
    hi = cw_t'((1 << (DW - 1)) - 1);
    lo = -hi - cw_t'(1);
    if (v > hi) return fx_t'(hi);
    if (v < lo) return fx_t'(lo);
    return fx_t'(v);
  endfunction

  // x1*y1 + x2*y2, rounded back to the fraction grid
  function automatic fx_t mac2(input fx_t x1, input fx_t y1,
                               input fx_t x2, input fx_t y2);
    acc_t acc;
    acc = acc_t'(x1) * acc_t'(y1) + acc_t'(x2) * acc_t'(y2)
        + acc_t'(1 << (FW - 1));
    return fx_t'(acc >>> FW);
  endfunction

  // [cl sl; -sl cl] * P * [cr -sr; sr cr]
  function automatic quad_t rotate2(input quad_t p, input fx_t cl, input fx_t sl,
                                    input fx_t cr, input fx_t sr);
    quad_t t;
    quad_t o;
    fx_t nsl;
    fx_t nsr;
    nsl = -sl;
    nsr = -sr;
    t.a = mac2(cl, p.a, sl, p.g);
    t.b = mac2(cl, p.b, sl, p.d);
    t.g = mac2(nsl, p.a, cl, p.g);
    t.d = mac2(nsl, p.b, cl, p.d);
    o.a = mac2(t.a, cr, t.b, sr);
    o.b = mac2(t.a, nsr, t.b, cr);
    o.g = mac2(t.g, cr, t.d, sr);
    o.d = mac2(t.g, nsr, t.d, cr);
    return o;
  endfunction
endpackage

// File: rtl/jrot_cordic.sv
module jrot_cordic
  import jrot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rot_mode,
  input  cw_t  x_in,
  input  cw_t  y_in,
  input  cw_t  z_in,
  output logic done,
  output cw_t  x_out,
  output cw_t  y_out,
  output cw_t  z_out
);
  localparam int CW = $clog2(NIT + 1);

  cw_t x_q, y_q, z_q;
  logic [CW-1:0] step_q;
  logic run_q, mode_q;
  cw_t xs, ys, ang;
  logic ccw;

  always_comb begin
    xs  = x_q >>> step_q;
    ys  = y_q >>> step_q;
    ang = atan_lut(int'(step_q));
    // rotation mode drives z to zero, vectoring mode drives y to zero
    ccw = mode_q ? !z_q[IW-1] : y_q[IW-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      z_q    <= '0;
      step_q <= '0;
      run_q  <= 1'b0;
      mode_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        x_q    <= x_in;
        y_q    <= y_in;
        z_q    <= z_in;
        step_q <= '0;
        run_q  <= 1'b1;
        mode_q <= rot_mode;
      end else if (run_q) begin
        if (ccw) begin
          x_q <= x_q - ys;
          y_q <= y_q + xs;
          z_q <= z_q - ang;
        end else begin
          x_q <= x_q + ys;
          y_q <= y_q - xs;
          z_q <= z_q + ang;
        end
        if (step_q == CW'(NIT - 1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  assign x_out = x_q;
  assign y_out = y_q;
  assign z_out = z_q;
endmodule

// File: rtl/jrot_pe.sv
module jrot_pe
  import jrot_pkg::*;
#(
  parameter role_e ROLE = ROLE_DIAG
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_a,
  input  logic signed [DW-1:0] in_b,
  input  logic signed [DW-1:0] in_g,
  input  logic signed [DW-1:0] in_d,
  input  logic signed [DW-1:0] row_c,
  input  logic signed [DW-1:0] row_s,
  input  logic signed [DW-1:0] col_c,
  input  logic signed [DW-1:0] col_s,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_a,
  output logic signed [DW-1:0] out_b,
  output logic signed [DW-1:0] out_g,
  output logic signed [DW-1:0] out_d,
  output logic signed [DW-1:0] out_c,
  output logic signed [DW-1:0] out_s
);
  typedef enum logic [2:0] {
    S_IDLE, S_VEC, S_VWAIT, S_ROT, S_RWAIT, S_APPLY, S_OUT
  } st_e;

  st_e   st_q;
  quad_t p_q, r_q;
  fx_t   rc_q, rs_q, c_q, s_q;
  cw_t   theta_q;

  // named events for the checker
  logic ev_accept, ev_emit, ev_angle;

  logic cdone, cstart, cmode;
  cw_t  cx, cy, cz, cx_in, cy_in, cz_in;
  cw_t  dx, dy, vx, vy;
  fx_t  lc, ls;
  quad_t r_next;

  assign in_ready  = (st_q == S_IDLE);
  assign out_valid = (st_q == S_OUT);
  assign ev_accept = in_valid && in_ready;
  assign ev_emit   = out_valid && out_ready;
  assign ev_angle  = cdone && (st_q == S_RWAIT);

  // vectoring operand: (a - d, 2b), folded into the right half-plane
  always_comb begin
    dx = cw_t'($signed(p_q.a)) - cw_t'($signed(p_q.d));
    dy = cw_t'($signed(p_q.b)) <<< 1;
    vx = dx[IW-1] ? -dx : dx;
    vy = dx[IW-1] ? -dy : dy;
  end

  assign cstart = (st_q == S_VEC) || (st_q == S_ROT);
  assign cmode  = (st_q == S_ROT);
  assign cx_in  = cmode ? GAIN_INV : vx;
  assign cy_in  = cmode ? cw_t'(0) : vy;
  assign cz_in  = cmode ? theta_q : cw_t'(0);

  generate
    if (ROLE == ROLE_DIAG) begin : g_angle
      jrot_cordic u_cordic (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (cstart),
        .rot_mode(cmode),
        .x_in    (cx_in),
        .y_in    (cy_in),
        .z_in    (cz_in),
        .done    (cdone),
        .x_out   (cx),
        .y_out   (cy),
        .z_out   (cz)
      );
    end else begin : g_no_angle
      assign cdone = 1'b0;
      assign cx    = '0;
      assign cy    = '0;
      assign cz    = '0;
    end
  endgenerate

  // left factor per role
  always_comb begin
    lc = c_q;
    ls = s_q;
    if (ROLE == ROLE_OFF) begin
      lc = rc_q;
      ls = rs_q;
    end else if (ROLE == ROLE_EIG) begin
      lc = FX_ONE;
      ls = '0;
    end
    r_next = rotate2(p_q, lc, ls, c_q, s_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      p_q     <= '0;
      r_q     <= '0;
      rc_q    <= '0;
      rs_q    <= '0;
      c_q     <= '0;
      s_q     <= '0;
      theta_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (ev_accept) begin
          p_q  <= '{a: in_a, b: in_b, g: in_g, d: in_d};
          rc_q <= row_c;
          rs_q <= row_s;
          if (ROLE != ROLE_DIAG) begin
            c_q  <= col_c;
            s_q  <= col_s;
            st_q <= S_APPLY;
          end else if (in_b == '0) begin
            theta_q <= '0;
            st_q    <= S_ROT;
          end else if (in_a == in_d) begin
            theta_q <= in_b[DW-1] ? -QUARTER_PI : QUARTER_PI;
            st_q    <= S_ROT;
          end else begin
            st_q <= S_VEC;
          end
        end
        S_VEC:   st_q <= S_VWAIT;
        S_VWAIT: if (cdone) begin
          theta_q <= cz >>> 1;
          st_q    <= S_ROT;
        end
        S_ROT:   st_q <= S_RWAIT;
        S_RWAIT: if (cdone) begin
          c_q  <= fx_sat(cx);
          s_q  <= fx_sat(cy);
          st_q <= S_APPLY;
        end
        S_APPLY: begin
          r_q  <= r_next;
          st_q <= S_OUT;
        end
        S_OUT:   if (out_ready) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign out_a = r_q.a;
  assign out_b = r_q.b;
  assign out_g = r_q.g;
  assign out_d = r_q.d;
  assign out_c = c_q;
  assign out_s = s_q;
endmodule

// File: rtl/jrot_pe_chk.sv
module jrot_pe_chk
  import jrot_pkg::*;
#(
  parameter role_e ROLE = ROLE_DIAG,
  parameter int    TOL  = TOL_LSB
) (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic ev_accept,
  input logic ev_emit,
  input logic ev_angle,
  input fx_t  in_b,
  input fx_t  in_g,
  input fx_t  col_c,
  input fx_t  col_s,
  input fx_t  out_a,
  input fx_t  out_b,
  input fx_t  out_g,
  input fx_t  out_d,
  input fx_t  out_c,
  input fx_t  out_s
);
  localparam acc_t UNIT = acc_t'(1) <<< (2 * FW);
  localparam acc_t NTOL = acc_t'(4 * TOL) <<< FW;
  localparam fx_t  CMIN = fx_t'(11500);

  logic sym_q, angle_seen_q;
  fx_t  colc_q, cols_q;
  logic [DW-1:0] bmag, gmag, smag;
  acc_t ssq, serr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym_q        <= 1'b0;
      angle_seen_q <= 1'b0;
      colc_q       <= '0;
      cols_q       <= '0;
    end else begin
      if (ev_accept) begin
        sym_q        <= (in_b == in_g);
        colc_q       <= col_c;
        cols_q       <= col_s;
        angle_seen_q <= 1'b0;
      end else if (ev_angle) begin
        angle_seen_q <= 1'b1;
      end
    end
  end

  always_comb begin
    bmag = out_b[DW-1] ? DW'(-out_b) : DW'(out_b);
    gmag = out_g[DW-1] ? DW'(-out_g) : DW'(out_g);
    smag = out_s[DW-1] ? DW'(-out_s) : DW'(out_s);
    ssq  = acc_t'(out_c) * acc_t'(out_c) + acc_t'(out_s) * acc_t'(out_s);
    serr = ssq - UNIT;
  end

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !in_ready);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_a) && $stable(out_b)
      && $stable(out_g) && $stable(out_d) && $stable(out_c) && $stable(out_s)));

  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_emit |=> (!out_valid && in_ready));

  p_angle_before_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ROLE == ROLE_DIAG && out_valid) |-> angle_seen_q);

  p_zeroed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ROLE == ROLE_DIAG && out_valid && sym_q) |->
      (bmag <= DW'(TOL) && gmag <= DW'(TOL)));

  p_cos_band_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ROLE == ROLE_DIAG && out_valid) |->
      (out_c >= CMIN && smag <= DW'(out_c) + DW'(TOL)));

  p_unit_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ROLE == ROLE_DIAG && out_valid) |-> (serr <= NTOL && serr >= -NTOL));

  p_forward_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ROLE != ROLE_DIAG && out_valid) |-> (out_c == colc_q && out_s == cols_q));
endmodule

bind jrot_pe jrot_pe_chk #(.ROLE(ROLE), .TOL(jrot_pkg::TOL_LSB)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .ev_accept(ev_accept),
  .ev_emit  (ev_emit),
  .ev_angle (ev_angle),
  .in_b     (in_b),
  .in_g     (in_g),
  .col_c    (col_c),
  .col_s    (col_s),
  .out_a    (out_a),
  .out_b    (out_b),
  .out_g    (out_g),
  .out_d    (out_d),
  .out_c    (out_c),
  .out_s    (out_s)
);

// File: tb/jrot_pe_test.sv
module jrot_pe_test;
  import jrot_pkg::*;

  localparam int  CLK_NS = 10;
  localparam real PI     = 3.14159265358979;
  localparam real LSB    = 1.0 / 16384.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  logic iv[3], ir[3], ov[3], ordy[3];
  fx_t  ia, ib, ig, id, rwc, rws, clc, cls;
  fx_t  oa[3], ob[3], og[3], od[3], oc[3], os[3];

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  jrot_pe #(.ROLE(ROLE_DIAG)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[0]), .in_ready(ir[0]),
    .in_a(ia), .in_b(ib), .in_g(ig), .in_d(id),
    .row_c(rwc), .row_s(rws), .col_c(clc), .col_s(cls),
    .out_valid(ov[0]), .out_ready(ordy[0]),
    .out_a(oa[0]), .out_b(ob[0]), .out_g(og[0]), .out_d(od[0]),
    .out_c(oc[0]), .out_s(os[0]));

  jrot_pe #(.ROLE(ROLE_OFF)) uut_off (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[1]), .in_ready(ir[1]),
    .in_a(ia), .in_b(ib), .in_g(ig), .in_d(id),
    .row_c(rwc), .row_s(rws), .col_c(clc), .col_s(cls),
    .out_valid(ov[1]), .out_ready(ordy[1]),
    .out_a(oa[1]), .out_b(ob[1]), .out_g(og[1]), .out_d(od[1]),
    .out_c(oc[1]), .out_s(os[1]));

  jrot_pe #(.ROLE(ROLE_EIG)) uut_eig (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[2]), .in_ready(ir[2]),
    .in_a(ia), .in_b(ib), .in_g(ig), .in_d(id),
    .row_c(rwc), .row_s(rws), .col_c(clc), .col_s(cls),
    .out_valid(ov[2]), .out_ready(ordy[2]),
    .out_a(oa[2]), .out_b(ob[2]), .out_g(og[2]), .out_d(od[2]),
    .out_c(oc[2]), .out_s(os[2]));

  function automatic real q(input fx_t v);
    return real'(v) * LSB;
  endfunction

  function automatic fx_t tofx(input real r);
    return fx_t'(int'(r * 16384.0));
  endfunction

  task automatic check(input bit ok, input string req, input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %f expected %f", req, act, exp);
    end
  endtask

  task automatic near(input string req, input real act, input real exp, input real tol);
    real df;
    df = act - exp;
    if (df < 0.0) df = -df;
    check(df <= tol, req, act, exp);
  endtask

  // row-major 2x2 product
  task automatic mm(input real x[4], input real y[4], output real z[4]);
    z[0] = x[0] * y[0] + x[1] * y[2];
    z[1] = x[0] * y[1] + x[1] * y[3];
    z[2] = x[2] * y[0] + x[3] * y[2];
    z[3] = x[2] * y[1] + x[3] * y[3];
  endtask

  // one job through cell k, with handshake checks (R2)
  task automatic job(input int k);
    int n;
    fx_t ha, hb, hc;
    @(negedge clk);
    check(ir[k] == 1'b1, "R2 idle before job", real'(ir[k]), 1.0);
    iv[k] = 1'b1;
    @(negedge clk);
    iv[k] = 1'b0;
    check(ir[k] == 1'b0, "R2 busy after accept", real'(ir[k]), 0.0);
    n = 0;
    while (!ov[k] && n < 400) begin
      @(negedge clk);
      n++;
    end
    check(ov[k] == 1'b1, "R2 result arrives", real'(ov[k]), 1.0);
    ha = oa[k]; hb = ob[k]; hc = oc[k];
    repeat (2) @(negedge clk);
    check(ov[k] == 1'b1 && oa[k] == ha && ob[k] == hb && oc[k] == hc,
          "R2 held while not ready", q(oa[k]), q(ha));
    ordy[k] = 1'b1;
    @(negedge clk);
    ordy[k] = 1'b0;
    check(ov[k] == 1'b0 && ir[k] == 1'b1, "R2 released after take",
          real'(ov[k]), 0.0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R2 watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    real grid[5];
    real ang[5];
    for (int k = 0; k < 3; k++) begin
      iv[k] = 1'b0;
      ordy[k] = 1'b0;
    end
    ia = '0; ib = '0; ig = '0; id = '0;
    rwc = '0; rws = '0; clc = '0; cls = '0;
    grid = '{-0.45, -0.2, 0.0, 0.2, 0.45};
    ang  = '{-0.7, -0.3, 0.0, 0.4, 0.78};

    // R1: reset state
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++)
      check(ov[k] == 1'b0 && ir[k] == 1'b1, "R1 during reset", real'(ov[k]), 0.0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 3; k++)
      check(ov[k] == 1'b0 && ir[k] == 1'b1, "R1 after reset", real'(ov[k]), 0.0);

    // angle cell: sweep symmetric tiles over a grid (R3 R4 R5 R6)
    for (int xa = 0; xa < 5; xa++) begin
      for (int xb = 0; xb < 5; xb++) begin
        for (int xd = 0; xd < 5; xd++) begin
          real a, b, d, th, c, s, ea, ed, sin2, sout;
          bit special;
          ia = tofx(grid[xa]); ib = tofx(grid[xb]); ig = ib; id = tofx(grid[xd]);
          job(0);
          a = q(ia); b = q(ib); d = q(id);
          special = (ib == 0) || (ia == id);
          if (ib == 0) th = 0.0;
          else if (ia == id) th = (b > 0.0) ? PI / 4.0 : -PI / 4.0;
          else th = 0.5 * $atan(2.0 * b / (a - d));
          c = $cos(th); s = $sin(th);
          ea = c * c * a + 2.0 * c * s * b + s * s * d;
          ed = s * s * a - 2.0 * c * s * b + c * c * d;
          near("R3 b cleared", q(ob[0]), 0.0, 16.0 * LSB);
          near("R3 g cleared", q(og[0]), 0.0, 16.0 * LSB);
          near("R3 a eigen", q(oa[0]), ea, 16.0 * LSB);
          near("R3 d eigen", q(od[0]), ed, 16.0 * LSB);
          if (special) begin
            near("R5 cos special", q(oc[0]), c, 8.0 * LSB);
            near("R5 sin special", q(os[0]), s, 8.0 * LSB);
            if (ib == 0) begin
              near("R5 unchanged a", q(oa[0]), a, 16.0 * LSB);
              near("R5 unchanged d", q(od[0]), d, 16.0 * LSB);
            end
          end else begin
            near("R4 cos", q(oc[0]), c, 8.0 * LSB);
            near("R4 sin", q(os[0]), s, 8.0 * LSB);
          end
          sin2 = a * a + 2.0 * b * b + d * d;
          sout = q(oa[0]) ** 2 + q(ob[0]) ** 2 + q(og[0]) ** 2 + q(od[0]) ** 2;
          near("R6 sum of squares", sout, sin2, 0.002);
          near("R6 unit pair", q(oc[0]) ** 2 + q(os[0]) ** 2, 1.0, 0.004);
        end
      end
    end

    // cross cell: two-sided rotation (R7)
    for (int i = 0; i < 5; i++) begin
      for (int j = 0; j < 5; j++) begin
        for (int pv = 0; pv < 2; pv++) begin
          real lm[4], pm[4], rm[4], tm[4], em[4];
          rwc = tofx($cos(ang[i])); rws = tofx($sin(ang[i]));
          clc = tofx($cos(ang[j])); cls = tofx($sin(ang[j]));
          if (pv == 0) begin
            ia = tofx(-0.4); ib = tofx(0.1); ig = tofx(0.35); id = tofx(-0.2);
          end else begin
            ia = tofx(0.3); ib = tofx(-0.25); ig = tofx(0.15); id = tofx(0.4);
          end
          job(1);
          lm = '{q(rwc), q(rws), -q(rws), q(rwc)};
          pm = '{q(ia), q(ib), q(ig), q(id)};
          rm = '{q(clc), -q(cls), q(cls), q(clc)};
          mm(lm, pm, tm);
          mm(tm, rm, em);
          near("R7 a", q(oa[1]), em[0], 4.0 * LSB);
          near("R7 b", q(ob[1]), em[1], 4.0 * LSB);
          near("R7 g", q(og[1]), em[2], 4.0 * LSB);
          near("R7 d", q(od[1]), em[3], 4.0 * LSB);
          check(oc[1] == clc && os[1] == cls, "R7 pair forwarded", q(oc[1]), q(clc));
        end
      end
    end

    // vector cell: identity start (R9)
    for (int j = 0; j < 5; j++) begin
      real c, s;
      clc = tofx($cos(ang[j])); cls = tofx($sin(ang[j]));
      rwc = tofx(0.123); rws = tofx(-0.456);
      ia = FX_ONE; ib = '0; ig = '0; id = FX_ONE;
      job(2);
      c = q(clc); s = q(cls);
      near("R9 a", q(oa[2]), c, 3.0 * LSB);
      near("R9 b", q(ob[2]), -s, 3.0 * LSB);
      near("R9 g", q(og[2]), s, 3.0 * LSB);
      near("R9 d", q(od[2]), c, 3.0 * LSB);
    end

    // vector cell: one-sided rotation, row pair ignored (R8)
    for (int j = 0; j < 5; j++) begin
      real pm[4], rm[4], em[4];
      fx_t sa, sb, sg, sd;
      clc = tofx($cos(ang[j])); cls = tofx($sin(ang[j]));
      ia = tofx(0.3); ib = tofx(-0.1); ig = tofx(0.2); id = tofx(0.25);
      rwc = tofx(0.9); rws = tofx(0.3);
      job(2);
      sa = oa[2]; sb = ob[2]; sg = og[2]; sd = od[2];
      pm = '{q(ia), q(ib), q(ig), q(id)};
      rm = '{q(clc), -q(cls), q(cls), q(clc)};
      mm(pm, rm, em);
      near("R8 a", q(sa), em[0], 4.0 * LSB);
      near("R8 b", q(sb), em[1], 4.0 * LSB);
      near("R8 g", q(sg), em[2], 4.0 * LSB);
      near("R8 d", q(sd), em[3], 4.0 * LSB);
      rwc = tofx(-0.2); rws = tofx(-0.95);
      job(2);
      check(oa[2] == sa && ob[2] == sb && og[2] == sg && od[2] == sd,
            "R8 row pair ignored", q(oa[2]), q(sa));
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule